// File: doc/BRIEF.md
# Flash Modify-Permission and Suspend Controller

This block sits between a host command port and a behavioural model of a flash array. The array is split into `NUM_BLOCKS` erase blocks of `WORDS_PER_BLOCK` words each. The host sends one command per cycle while `cmd_ready` is high. Each program or erase request is screened against every protection layer before it may start: the reset input, the global modify-enable pin, the write-protect pin combined with a per-block shield map, and an optional password lock. A refused request never touches the array, and the reason is recorded in sticky status flags.

Array operations take a fixed number of cycles. A running erase can be frozen with a suspend command. While the erase is frozen, reads and programs may target any other block. A frozen program permits only reads. A resume command continues the frozen operation from where it stopped. Erased words read as all ones, and a program ANDs the new word into the stored word.

Top module: `fpc_ctrl`

## Requirements
- R1: After reset the following hold: every bit of the shield map is set, `burst_cfg` is 0 (asynchronous bus), and `status` shows only the ready flag (0x01).
- R2: While `rst_n` is low, `status` and `burst_cfg` read 0, commands are ignored, and any running operation is abandoned.
- R3: After `rst_n` rises, `cmd_ready` stays low for `RECOV_CYC` cycles, and commands offered during that time have no effect.
- R4: While `prog_en` is low, every program and erase is refused.
- R5: While `wp` is high, blocks whose shield bit is set refuse program and erase. Opcode 5 sets the shield bit of `cmd_blk` and opcode 6 clears it, one block per command.
- R6: An erase (opcode 2) is suspended by opcode 3. While it is suspended, reads of any block and programs (opcode 1) to other blocks run, and a new erase is refused with the erase-error flag. Opcode 4 resumes the erase and finishes it.
- R7: While a program is suspended, reads still work, and any program or erase is refused with its error flag. Resume finishes the program.
- R8: Opcode 7 stores `cmd_data` as a 64-bit key and engages a lock that refuses program and erase. Opcode 8 with the matching key releases the lock; opcode 8 with a different key leaves it engaged. While `pwd_off` is high, opcode 7 is ignored and the lock has no effect.
- R9: Erase (opcode 2) sets every word of the block to all ones. Program (opcode 1) stores the AND of the old word and the new word.
- R10: A request refused by a protection layer sets status bit 4 along with its operation error flag (bit 2 for program, bit 3 for erase) and leaves the array unchanged.
- R11: Status bits are: 0 ready, 1 suspended, 2 program error, 3 erase error, 4 protection error. Error bits stay set until opcode 9 is accepted while the block is not busy.
- R12: A program aimed at the block whose erase is suspended is refused with bit 2 only, and that block keeps its contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset / power-down |
| prog_en | input | 1 | Global modify enable, high permits program and erase |
| wp | input | 1 | Write-protect, high enforces the shield map |
| pwd_off | input | 1 | Strap, high disables the password lock permanently |
| cmd_valid | input | 1 | Command present |
| cmd_op | input | 4 | Opcode (0 nop, 1 program, 2 erase, 3 suspend, 4 resume, 5 shield set, 6 shield clear, 7 lock, 8 unlock, 9 clear status, 10 bus config) |
| cmd_blk | input | 7 | Target block |
| cmd_word | input | 2 | Word within block |
| cmd_data | input | 64 | Program data (low 32 bits), key, or bus configuration (low 16 bits) |
| cmd_ready | output | 1 | Recovery interval over, commands are sampled |
| status | output | 8 | Status flags as listed in R11 |
| burst_cfg | output | 16 | Bus configuration register, 0 means asynchronous |
| rd_blk | input | 7 | Read block address |
| rd_word | input | 2 | Read word address |
| rd_data | output | 32 | Read word, valid one cycle after the address |

## Verification
The bound checker watches every cycle for the following: an operation that starts while `prog_en` is low, while the lock is engaged, while a shielded block is write-protected, or during recovery; an erase that starts while another erase is suspended; any start while a program is suspended; and an error flag that drops without a clear command. The checker cannot see what the array holds. Only the bench scenarios show the AND-merge of programs, an erase that survives a suspend and resume, the nested program that runs during an erase suspend, the correct key matching for unlock, and the loss of state across a mid-operation reset.

// File: rtl/fpc_pkg.sv
`timescale 1ns/1ps
package fpc_pkg;
   typedef enum logic [3:0] {
      OP_NOP     = 4'd0,
      OP_PROG    = 4'd1,
      OP_ERASE   = 4'd2,
      OP_SUSP    = 4'd3,
      OP_RESUME  = 4'd4,
      OP_PSET    = 4'd5,
      OP_PCLR    = 4'd6,
      OP_LOCK    = 4'd7,
      OP_UNLOCK  = 4'd8,
      OP_CLRSTAT = 4'd9,
      OP_BUSCFG  = 4'd10
   } op_e;

   localparam int ST_W    = 8;
   localparam int ST_RDY  = 0;
   localparam int ST_SUSP = 1;
   localparam int ST_PERR = 2;
   localparam int ST_EERR = 3;
   localparam int ST_XERR = 4;
endpackage

// File: rtl/fpc_lock.sv
`timescale 1ns/1ps
module fpc_lock #(
   parameter int KEY_W  = 64,
   parameter bit ENABLE = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             lock_cmd,
   input  logic             unlock_cmd,
   input  logic [KEY_W-1:0] key,
   input  logic             strap_off,
   output logic             lock_active
);
   if (KEY_W < 8) begin : g_bad_key
      $error("fpc_lock: KEY_W too small");
   end

   if (ENABLE) begin : g_lock
      logic [KEY_W-1:0] key_q;
      logic             engaged_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            key_q     <= '0;
            engaged_q <= 1'b0;
         end else if (lock_cmd && !strap_off) begin
            key_q     <= key;
            engaged_q <= 1'b1;
         end else if (unlock_cmd && key == key_q) begin
            engaged_q <= 1'b0;
         end
      end
      assign lock_active = engaged_q && !strap_off;
   end else begin : g_nolock
      logic unused_lock;
      assign unused_lock = ^{clk, rst_n, lock_cmd, unlock_cmd, key, strap_off};
      assign lock_active = 1'b0;
   end
endmodule

// File: rtl/fpc_array.sv
`timescale 1ns/1ps
module fpc_array #(
   parameter int NB  = 74,
   parameter int WPB = 4,
   parameter int DW  = 32
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   wr_prog,
   input  logic                   wr_erase,
   input  logic [$clog2(NB)-1:0]  wr_blk,
   input  logic [$clog2(WPB)-1:0] wr_word,
   input  logic [DW-1:0]          wr_data,
   input  logic [$clog2(NB)-1:0]  rd_blk,
   input  logic [$clog2(WPB)-1:0] rd_word,
   output logic [DW-1:0]          rd_data
);
   localparam int BLK_W = $clog2(NB);
   localparam int WRD_W = $clog2(WPB);
   localparam int CELLS = NB * WPB;

   if (WPB < 2 || (1 << WRD_W) != WPB) begin : g_bad_wpb
      $error("fpc_array: WPB must be a power of two, at least 2");
   end

   logic [CELLS*DW-1:0] flat;

   for (genvar b = 0; b < NB; b++) begin : g_blk
      for (genvar w = 0; w < WPB; w++) begin : g_word
         logic [DW-1:0] cell_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               cell_q <= '1;
            else if (wr_erase && wr_blk == BLK_W'(b))
               cell_q <= '1;
            else if (wr_prog && wr_blk == BLK_W'(b) && wr_word == WRD_W'(w))
               cell_q <= cell_q & wr_data;
         end
         assign flat[(b*WPB+w)*DW +: DW] = cell_q;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         rd_data <= '0;
      else if (int'(rd_blk) < NB)
         rd_data <= flat[(int'(rd_blk)*WPB + int'(rd_word))*DW +: DW];
      else
         rd_data <= '1;
   end
endmodule

// File: rtl/fpc_seq.sv
`timescale 1ns/1ps
module fpc_seq import fpc_pkg::*; #(
   parameter int NB        = 74,
   parameter int WPB       = 4,
   parameter int DW        = 32,
   parameter int PROG_CYC  = 4,
   parameter int ERASE_CYC = 16
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   cmd_go,
   input  op_e                    op,
   input  logic [$clog2(NB)-1:0]  blk,
   input  logic [$clog2(WPB)-1:0] word,
   input  logic [DW-1:0]          data,
   input  logic                   allowed,
   output logic                   busy,
   output logic                   op_start,
   output logic                   susp_prog,
   output logic [ST_W-1:0]        status,
   output logic                   wr_prog,
   output logic                   wr_erase,
   output logic [$clog2(NB)-1:0]  wr_blk,
   output logic [$clog2(WPB)-1:0] wr_word,
   output logic [DW-1:0]          wr_data
);
   localparam int BLK_W = $clog2(NB);
   localparam int WRD_W = $clog2(WPB);
   localparam int MAXC  = (ERASE_CYC > PROG_CYC) ? ERASE_CYC : PROG_CYC;
   localparam int CNT_W = $clog2(MAXC + 1);

   if (PROG_CYC < 1 || ERASE_CYC < 1) begin : g_bad_cyc
      $error("fpc_seq: operation lengths must be at least one cycle");
   end

   // frozen-able main operation
   logic             act_q, act_er_q, susp_q;
   logic [BLK_W-1:0] act_blk_q;
   logic [WRD_W-1:0] act_word_q;
   logic [DW-1:0]    act_data_q;
   logic [CNT_W-1:0] act_cnt_q;
   // program nested inside an erase suspend
   logic             nst_q;
   logic [BLK_W-1:0] nst_blk_q;
   logic [WRD_W-1:0] nst_word_q;
   logic [DW-1:0]    nst_data_q;
   logic [CNT_W-1:0] nst_cnt_q;
   logic             perr_q, eerr_q, xerr_q;

   logic run_main, main_done, nst_done;
   logic is_prog, is_erase, seq_rej, prog_ok, erase_ok;
   logic do_susp, do_resume, do_clr;

   always_comb begin
      run_main  = act_q && !susp_q;
      main_done = run_main && act_cnt_q == '0;
      nst_done  = nst_q && nst_cnt_q == '0;
      busy      = run_main || nst_q;
      is_prog   = cmd_go && op == OP_PROG  && !busy;
      is_erase  = cmd_go && op == OP_ERASE && !busy;
      seq_rej   = susp_q && (!act_er_q || blk == act_blk_q);
      prog_ok   = is_prog && !seq_rej && allowed;
      erase_ok  = is_erase && !susp_q && allowed;
      op_start  = prog_ok || erase_ok;
      do_susp   = cmd_go && op == OP_SUSP && run_main && !main_done;
      do_resume = cmd_go && op == OP_RESUME && susp_q && !nst_q;
      do_clr    = cmd_go && op == OP_CLRSTAT && !busy;
      susp_prog = susp_q && !act_er_q;
   end

   always_comb begin
      wr_prog  = (main_done && !act_er_q) || nst_done;
      wr_erase = main_done && act_er_q;
      wr_blk   = nst_done ? nst_blk_q  : act_blk_q;
      wr_word  = nst_done ? nst_word_q : act_word_q;
      wr_data  = nst_done ? nst_data_q : act_data_q;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         act_q      <= 1'b0;
         act_er_q   <= 1'b0;
         susp_q     <= 1'b0;
         act_blk_q  <= '0;
         act_word_q <= '0;
         act_data_q <= '0;
         act_cnt_q  <= '0;
      end else begin
         if (main_done)
            act_q <= 1'b0;
         else if (run_main)
            act_cnt_q <= act_cnt_q - 1'b1;
         if (op_start && !susp_q) begin
            act_q      <= 1'b1;
            act_er_q   <= erase_ok;
            act_blk_q  <= blk;
            act_word_q <= word;
            act_data_q <= data;
            act_cnt_q  <= erase_ok ? CNT_W'(ERASE_CYC - 1) : CNT_W'(PROG_CYC - 1);
         end
         if (do_susp)
            susp_q <= 1'b1;
         else if (do_resume)
            susp_q <= 1'b0;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         nst_q      <= 1'b0;
         nst_blk_q  <= '0;
         nst_word_q <= '0;
         nst_data_q <= '0;
         nst_cnt_q  <= '0;
      end else if (nst_done) begin
         nst_q <= 1'b0;
      end else if (nst_q) begin
         nst_cnt_q <= nst_cnt_q - 1'b1;
      end else if (prog_ok && susp_q) begin
         nst_q      <= 1'b1;
         nst_blk_q  <= blk;
         nst_word_q <= word;
         nst_data_q <= data;
         nst_cnt_q  <= CNT_W'(PROG_CYC - 1);
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         perr_q <= 1'b0;
         eerr_q <= 1'b0;
         xerr_q <= 1'b0;
      end else if (do_clr) begin
         perr_q <= 1'b0;
         eerr_q <= 1'b0;
         xerr_q <= 1'b0;
      end else begin
         if (is_prog && !prog_ok)
            perr_q <= 1'b1;
         if (is_erase && !erase_ok)
            eerr_q <= 1'b1;
         if ((is_prog && !seq_rej && !allowed) || (is_erase && !susp_q && !allowed))
            xerr_q <= 1'b1;
      end
   end

   always_comb begin
      status          = '0;
      status[ST_RDY]  = !busy;
      status[ST_SUSP] = susp_q;
      status[ST_PERR] = perr_q;
      status[ST_EERR] = eerr_q;
      status[ST_XERR] = xerr_q;
   end
endmodule

// File: rtl/fpc_ctrl.sv
`timescale 1ns/1ps
module fpc_ctrl import fpc_pkg::*; #(
   parameter int NUM_BLOCKS      = 74,
   parameter int WORDS_PER_BLOCK = 4,
   parameter int DATA_W          = 32,
   parameter int KEY_W           = 64,
   parameter int BURST_W         = 16,
   parameter int PROG_CYC        = 4,
   parameter int ERASE_CYC       = 16,
   parameter int RECOV_CYC       = 8,
   parameter bit HAS_PASSWORD    = 1'b1
) (
   input  logic                               clk,
   input  logic                               rst_n,
   input  logic                               prog_en,
   input  logic                               wp,
   input  logic                               pwd_off,
   input  logic                               cmd_valid,
   input  logic [3:0]                         cmd_op,
   input  logic [$clog2(NUM_BLOCKS)-1:0]      cmd_blk,
   input  logic [$clog2(WORDS_PER_BLOCK)-1:0] cmd_word,
   input  logic [KEY_W-1:0]                   cmd_data,
   output logic                               cmd_ready,
   output logic [ST_W-1:0]                    status,
   output logic [BURST_W-1:0]                 burst_cfg,
   input  logic [$clog2(NUM_BLOCKS)-1:0]      rd_blk,
   input  logic [$clog2(WORDS_PER_BLOCK)-1:0] rd_word,
   output logic [DATA_W-1:0]                  rd_data
);
   localparam int REC_W = $clog2(RECOV_CYC + 1);

   if (KEY_W < DATA_W || KEY_W < BURST_W) begin : g_bad_key
      $error("fpc_ctrl: KEY_W must cover DATA_W and BURST_W");
   end
   if (RECOV_CYC < 1 || NUM_BLOCKS < 2) begin : g_bad_cfg
      $error("fpc_ctrl: RECOV_CYC and NUM_BLOCKS out of range");
   end

   op_e                     op;
   logic [REC_W-1:0]        rec_q;
   logic [NUM_BLOCKS-1:0]   prot_q;
   logic [BURST_W-1:0]      bus_q;
   logic                    cmd_go, idle_go, busy, blk_ok, lock_active, allowed;
   logic                    op_start, susp_prog;
   logic [ST_W-1:0]         seq_status;
   logic                    wr_prog, wr_erase;
   logic [$clog2(NUM_BLOCKS)-1:0]      wr_blk;
   logic [$clog2(WORDS_PER_BLOCK)-1:0] wr_word;
   logic [DATA_W-1:0]                  wr_data;

   assign op        = op_e'(cmd_op);
   assign cmd_ready = rec_q == '0;
   assign cmd_go    = cmd_valid && cmd_ready;
   assign idle_go   = cmd_go && !busy;
   assign blk_ok    = int'(cmd_blk) < NUM_BLOCKS;
   assign allowed   = prog_en && blk_ok && !(wp && prot_q[cmd_blk]) && !lock_active;
   assign status    = rst_n ? seq_status : '0;
   assign burst_cfg = bus_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         rec_q <= REC_W'(RECOV_CYC);
      else if (rec_q != '0)
         rec_q <= rec_q - 1'b1;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         prot_q <= '1;
         bus_q  <= '0;
      end else if (idle_go) begin
         if (op == OP_PSET && blk_ok)
            prot_q[cmd_blk] <= 1'b1;
         if (op == OP_PCLR && blk_ok)
            prot_q[cmd_blk] <= 1'b0;
         if (op == OP_BUSCFG)
            bus_q <= cmd_data[BURST_W-1:0];
      end
   end

   fpc_lock #(.KEY_W(KEY_W), .ENABLE(HAS_PASSWORD)) u_lock (
      .clk(clk), .rst_n(rst_n),
      .lock_cmd(idle_go && op == OP_LOCK),
      .unlock_cmd(idle_go && op == OP_UNLOCK),
      .key(cmd_data), .strap_off(pwd_off), .lock_active(lock_active)
   );

   fpc_seq #(.NB(NUM_BLOCKS), .WPB(WORDS_PER_BLOCK), .DW(DATA_W),
             .PROG_CYC(PROG_CYC), .ERASE_CYC(ERASE_CYC)) u_seq (
      .clk(clk), .rst_n(rst_n), .cmd_go(cmd_go), .op(op), .blk(cmd_blk),
      .word(cmd_word), .data(cmd_data[DATA_W-1:0]), .allowed(allowed),
      .busy(busy), .op_start(op_start), .susp_prog(susp_prog),
      .status(seq_status), .wr_prog(wr_prog), .wr_erase(wr_erase),
      .wr_blk(wr_blk), .wr_word(wr_word), .wr_data(wr_data)
   );

   fpc_array #(.NB(NUM_BLOCKS), .WPB(WORDS_PER_BLOCK), .DW(DATA_W)) u_array (
      .clk(clk), .rst_n(rst_n), .wr_prog(wr_prog), .wr_erase(wr_erase),
      .wr_blk(wr_blk), .wr_word(wr_word), .wr_data(wr_data),
      .rd_blk(rd_blk), .rd_word(rd_word), .rd_data(rd_data)
   );
endmodule

// File: rtl/fpc_ctrl_chk.sv
`timescale 1ns/1ps
module fpc_ctrl_chk import fpc_pkg::*; #(
   parameter int NB    = 74,
   parameter int BLK_W = 7
) (
   input logic             clk,
   input logic             rst_n,
   input logic             prog_en,
   input logic             wp,
   input logic             cmd_ready,
   input logic             cmd_go,
   input logic [3:0]       cmd_op,
   input logic [BLK_W-1:0] cmd_blk,
   input logic [ST_W-1:0]  status,
   input logic             op_start,
   input logic             susp_prog,
   input logic             lock_active,
   input logic [NB-1:0]    prot_q
);
   AST_START_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
      op_start |-> prog_en);                                              // R4
   AST_SHIELD_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      (op_start && wp) |-> !prot_q[cmd_blk]);                             // R5
   AST_LOCK_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      op_start |-> !lock_active);                                         // R8
   AST_RECOVERY_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      !cmd_ready |-> !op_start);                                          // R3
   AST_NO_ERASE_IN_SUSPEND: assert property (@(posedge clk) disable iff (!rst_n)
      status[ST_SUSP] |-> !(op_start && cmd_op == OP_ERASE));             // R6
   AST_PROG_SUSPEND_READ_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
      susp_prog |-> !op_start);                                           // R7
   AST_ERROR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      (status[ST_PERR] && !(cmd_go && cmd_op == OP_CLRSTAT)) |=> status[ST_PERR]); // R11
endmodule

bind fpc_ctrl fpc_ctrl_chk #(.NB(NUM_BLOCKS), .BLK_W($clog2(NUM_BLOCKS))) u_chk (
   .clk(clk), .rst_n(rst_n), .prog_en(prog_en), .wp(wp), .cmd_ready(cmd_ready),
   .cmd_go(cmd_go), .cmd_op(cmd_op), .cmd_blk(cmd_blk), .status(status),
   .op_start(op_start), .susp_prog(susp_prog), .lock_active(lock_active),
   .prot_q(prot_q)
);

// File: tb/fpc_ctrl_test.sv
`timescale 1ns/1ps
module fpc_ctrl_test;
   import fpc_pkg::*;

   logic        clk = 1'b0;
   logic        rst_n, prog_en, wp, pwd_off, cmd_valid;
   logic [3:0]  cmd_op;
   logic [6:0]  cmd_blk, rd_blk;
   logic [1:0]  cmd_word, rd_word;
   logic [63:0] cmd_data;
   logic        cmd_ready;
   logic [7:0]  status;
   logic [15:0] burst_cfg;
   logic [31:0] rd_data;

   int n_checks = 0;
   int n_errors = 0;

   always #2.5 clk = ~clk;

   fpc_ctrl uut (
      .clk(clk), .rst_n(rst_n), .prog_en(prog_en), .wp(wp), .pwd_off(pwd_off),
      .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_blk(cmd_blk), .cmd_word(cmd_word),
      .cmd_data(cmd_data), .cmd_ready(cmd_ready), .status(status),
      .burst_cfg(burst_cfg), .rd_blk(rd_blk), .rd_word(rd_word), .rd_data(rd_data)
   );

   task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_errors++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   // scoreboard for the read path
   logic [31:0] exp_q[$];
   string       tag_q[$];
   logic        rd_req = 1'b0;
   logic        rd_req_q = 1'b0;

   always @(posedge clk) rd_req_q <= rd_req;

   always @(negedge clk) begin
      if (rd_req_q && exp_q.size() > 0) begin
         check(tag_q.pop_front(), {32'h0, rd_data}, {32'h0, exp_q.pop_front()});
      end
   end

   task automatic read_exp(input int blk, input int word, input logic [31:0] exp, input string tag);
      @(posedge clk); #1;
      rd_blk  = 7'(blk);
      rd_word = 2'(word);
      rd_req  = 1'b1;
      exp_q.push_back(exp);
      tag_q.push_back(tag);
      @(posedge clk); #1;
      rd_req = 1'b0;
      @(negedge clk);
   endtask

   task automatic issue(input op_e op, input int blk, input int word, input logic [63:0] data);
      @(posedge clk); #1;
      cmd_valid = 1'b1;
      cmd_op    = op;
      cmd_blk   = 7'(blk);
      cmd_word  = 2'(word);
      cmd_data  = data;
      @(posedge clk); #1;
      cmd_valid = 1'b0;
      cmd_op    = OP_NOP;
   endtask

   task automatic wait_ready(input string tag);
      bit seen = 1'b0;
      for (int i = 0; i < 200; i++) begin
         @(negedge clk);
         if (status[ST_RDY]) begin
            seen = 1'b1;
            break;
         end
      end
      if (!seen) check({tag, " ready timeout"}, 64'd0, 64'd1);
   endtask

   task automatic chk_status(input logic [7:0] exp, input string tag);
      @(negedge clk);
      check(tag, {56'h0, status}, {56'h0, exp});
   endtask

   initial begin
      #(200000 * 5);
      n_errors++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
      $finish;
   end

   initial begin
      rst_n = 1'b0; prog_en = 1'b1; wp = 1'b0; pwd_off = 1'b0;
      cmd_valid = 1'b0; cmd_op = OP_NOP; cmd_blk = '0; cmd_word = '0; cmd_data = '0;
      rd_blk = '0; rd_word = '0;
      repeat (4) @(posedge clk);
      chk_status(8'h00, "R2 status zero in reset");
      check("R2 burst cfg zero in reset", {48'h0, burst_cfg}, 64'h0);

      // release, then a command during recovery must be lost
      @(posedge clk); #1; rst_n = 1'b1;
      @(negedge clk);
      check("R3 not ready after release", {63'h0, cmd_ready}, 64'h0);
      issue(OP_BUSCFG, 0, 0, 64'h1234);
      repeat (10) @(posedge clk);
      @(negedge clk);
      check("R3 recovery command ignored", {48'h0, burst_cfg}, 64'h0);
      check("R3 ready after recovery", {63'h0, cmd_ready}, 64'h1);
      chk_status(8'h01, "R1 status after reset");

      // power-up shield map, enforced by wp
      wp = 1'b1;
      issue(OP_PROG, 3, 0, 64'h0);
      chk_status(8'h15, "R1 R10 shielded program refused");
      read_exp(3, 0, 32'hFFFF_FFFF, "R10 shielded block unchanged");
      issue(OP_CLRSTAT, 0, 0, 64'h0);
      chk_status(8'h01, "R11 clear status");

      issue(OP_PCLR, 3, 0, 64'h0);
      issue(OP_PROG, 3, 0, 64'h1234_5678);
      wait_ready("R5");
      chk_status(8'h01, "R5 unshielded program clean");
      read_exp(3, 0, 32'h1234_5678, "R5 program after shield clear");
      issue(OP_PSET, 3, 0, 64'h0);
      issue(OP_ERASE, 3, 0, 64'h0);
      chk_status(8'h19, "R5 R10 erase of reshielded block refused");
      read_exp(3, 0, 32'h1234_5678, "R10 refused erase kept data");
      issue(OP_CLRSTAT, 0, 0, 64'h0);

      // wp low: shield map not enforced; AND merge and erase
      wp = 1'b0;
      issue(OP_PROG, 3, 0, 64'hFF00_FF00);
      wait_ready("R9");
      read_exp(3, 0, 32'h1200_5600, "R9 program ANDs data");
      issue(OP_ERASE, 3, 0, 64'h0);
      wait_ready("R9");
      read_exp(3, 0, 32'hFFFF_FFFF, "R9 erase sets ones");
      read_exp(3, 1, 32'hFFFF_FFFF, "R9 erase covers block");

      // global enable
      prog_en = 1'b0;
      issue(OP_PROG, 9, 0, 64'h0);
      chk_status(8'h15, "R4 program refused with enable low");
      repeat (5) @(posedge clk);
      chk_status(8'h15, "R11 error stays set");
      read_exp(9, 0, 32'hFFFF_FFFF, "R4 array untouched");
      issue(OP_CLRSTAT, 0, 0, 64'h0);
      prog_en = 1'b1;

      // password lock
      issue(OP_LOCK, 0, 0, 64'hDEAD_BEEF_0123_4567);
      issue(OP_PROG, 9, 1, 64'h0);
      chk_status(8'h15, "R8 locked program refused");
      issue(OP_CLRSTAT, 0, 0, 64'h0);
      issue(OP_UNLOCK, 0, 0, 64'hDEAD_BEEF_0123_4566);
      issue(OP_ERASE, 9, 0, 64'h0);
      chk_status(8'h19, "R8 wrong key keeps lock");
      issue(OP_CLRSTAT, 0, 0, 64'h0);
      issue(OP_UNLOCK, 0, 0, 64'hDEAD_BEEF_0123_4567);
      issue(OP_PROG, 9, 2, 64'h0000_FFFF);
      wait_ready("R8");
      chk_status(8'h01, "R8 unlocked program clean");
      read_exp(9, 2, 32'h0000_FFFF, "R8 program after unlock");
      pwd_off = 1'b1;
      issue(OP_LOCK, 0, 0, 64'h1);
      issue(OP_PROG, 9, 3, 64'h0F0F_0F0F);
      wait_ready("R8");
      read_exp(9, 3, 32'h0F0F_0F0F, "R8 strap disables lock");

      // erase suspend
      issue(OP_PROG, 10, 0, 64'h0);
      wait_ready("R6");
      issue(OP_ERASE, 10, 0, 64'h0);
      issue(OP_SUSP, 0, 0, 64'h0);
      chk_status(8'h03, "R6 erase suspended");
      issue(OP_PROG, 11, 0, 64'hA5A5_A5A5);
      wait_ready("R6");
      chk_status(8'h03, "R6 nested program clean");
      read_exp(11, 0, 32'hA5A5_A5A5, "R6 program elsewhere during erase suspend");
      read_exp(10, 0, 32'h0000_0000, "R6 suspended erase not applied");
      issue(OP_PROG, 10, 1, 64'h0);
      chk_status(8'h07, "R12 program to suspended block refused");
      read_exp(10, 1, 32'hFFFF_FFFF, "R12 suspended block unchanged");
      issue(OP_ERASE, 12, 0, 64'h0);
      chk_status(8'h0F, "R6 erase during suspend refused");
      issue(OP_CLRSTAT, 0, 0, 64'h0);
      chk_status(8'h03, "R11 clear keeps suspend flag");
      issue(OP_RESUME, 0, 0, 64'h0);
      wait_ready("R6");
      chk_status(8'h01, "R6 resumed erase done");
      read_exp(10, 0, 32'hFFFF_FFFF, "R6 resumed erase applied");

      // program suspend
      issue(OP_PROG, 20, 0, 64'h0);
      issue(OP_SUSP, 0, 0, 64'h0);
      chk_status(8'h03, "R7 program suspended");
      read_exp(21, 0, 32'hFFFF_FFFF, "R7 read during program suspend");
      issue(OP_PROG, 21, 0, 64'h0);
      chk_status(8'h07, "R7 program during program suspend refused");
      issue(OP_ERASE, 21, 0, 64'h0);
      chk_status(8'h0F, "R7 erase during program suspend refused");
      issue(OP_CLRSTAT, 0, 0, 64'h0);
      issue(OP_RESUME, 0, 0, 64'h0);
      wait_ready("R7");
      read_exp(20, 0, 32'h0000_0000, "R7 resumed program applied");
      read_exp(21, 0, 32'hFFFF_FFFF, "R7 other block untouched");

      // reset mid-operation
      issue(OP_BUSCFG, 0, 0, 64'hBEEF);
      @(negedge clk);
      check("R2 bus config written", {48'h0, burst_cfg}, 64'hBEEF);
      issue(OP_ERASE, 20, 0, 64'h0);
      @(posedge clk); #1; rst_n = 1'b0;
      chk_status(8'h00, "R2 status cleared mid operation");
      check("R2 bus config cleared", {48'h0, burst_cfg}, 64'h0);
      @(posedge clk); #1; rst_n = 1'b1;
      repeat (10) @(posedge clk);
      chk_status(8'h01, "R2 operation abandoned");
      wp = 1'b1;
      issue(OP_PROG, 40, 0, 64'h0);
      chk_status(8'h15, "R1 shield restored by reset");

      repeat (3) @(posedge clk);
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
      $finish;
   end
endmodule